// File: doc/BRIEF.md
# Two-Wire Bus Master Command Engine

This block drives a two-wire serial bus (clock and open-drain data) as the only master on that bus, and runs one command at a time. A command carries a 7-bit target address, a direction, a start request and a byte count. Once the bus is idle and a command with the start request is written, the engine produces a START condition and sends the address with the direction bit. It then checks the address acknowledge. After that it moves the counted data bytes through a one-byte transmit buffer or a one-byte receive buffer. It closes the command with a STOP condition on its own.

The engine holds the bus clock low for as long as the buffer it needs is not ready. When writing, that means the transmit buffer is empty; when reading, it means the receive buffer still holds an unread byte. Firmware or a DMA channel can therefore run slower than the bus without losing data. The transmit-ready and receive-ready flags double as request lines for such channels. Status flags can each raise one interrupt line through an enable vector. The clock period comes from separate high and low phase counts. The data line is open drain, so a released output reads as 1.

Top module: `twm_master`

## Requirements
- R1: After reset the engine is idle: `idle`=1, `scl_o`=1, `sda_o`=1, `tx_ready`=1, `rx_ready`=0, `cmd_done`=0, `addr_nak`=0, `data_nak`=0.
- R2: A command is taken only when `cmd_wr` and `cmd_start` are both 1 while `idle`=1. A write with `cmd_start`=0 causes no bus activity and leaves `idle` at 1.
- R3: A command begins with a START (data falls while clock is high), then sends the address byte MSB first as `{cmd_addr, cmd_read}`; `cmd_read`=1 selects a read.
- R4: If the data line is high during the address acknowledge bit, `addr_nak` is set, no data bytes are clocked, and STOP follows.
- R5: In a write, each data byte is taken from the transmit buffer and sent MSB first. `tx_ready`=1 means the buffer is empty, and a `tx_wr` pulse fills it and clears `tx_ready`.
- R6: While the next byte's buffer is not ready (write: `tx_ready`=1; read: `rx_ready`=1), the clock is held low and no clock rising edge occurs.
- R7: In a read, each received byte appears on `rx_data` with `rx_ready` set, and a `rx_rd` pulse clears `rx_ready`. The master acknowledges (drives 0) every byte except the last, which it answers with a NAK (releases, 1).
- R8: In a write, a NAK on a data byte sets `data_nak`, no further data byte is sent, and STOP follows.
- R9: After the last byte, or after a NAK, STOP is sent (data rises while clock is high), `cmd_done` is set and `idle` returns to 1. Accepting a new command clears `cmd_done`, `addr_nak` and `data_nak`.
- R10: Apart from START and STOP, the data line changes only while the clock is low.
- R11: Every clock high pulse inside a transfer lasts exactly `div_high` cycles, and every low phase lasts at least `div_low` cycles.
- R12: `irq` is 1 when any status flag is set together with its enable bit. The enable bit positions are: bit 0 `cmd_done`, bit 1 `tx_ready`, bit 2 `rx_ready`, bit 3 `addr_nak`, bit 4 `data_nak`.
- R13: A command with a byte count of zero sends only START, the address and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command write strobe |
| cmd_start | input | 1 | Start request carried by the command |
| cmd_read | input | 1 | 1 = read from target, 0 = write to target |
| cmd_addr | input | 7 | Target address |
| cmd_count | input | CNT_W | Number of data bytes |
| div_high | input | DIV_W | Clock high phase in cycles (at least SDA_SYNC+1) |
| div_low | input | DIV_W | Clock low phase in cycles (at least 2) |
| tx_wr | input | 1 | Fill the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Empty the receive buffer |
| rx_data | output | 8 | Last received byte |
| int_en | input | 5 | Interrupt enables, positions as in R12 |
| idle | output | 1 | No command in progress |
| cmd_done | output | 1 | Command completed |
| tx_ready | output | 1 | Transmit buffer empty (DMA transmit request) |
| rx_ready | output | 1 | Receive buffer full (DMA receive request) |
| addr_nak | output | 1 | Address not acknowledged |
| data_nak | output | 1 | Written data byte not acknowledged |
| irq | output | 1 | Interrupt request |
| scl_o | output | 1 | Clock line output, 0 = drive low, 1 = release |
| sda_o | output | 1 | Data line output, 0 = drive low, 1 = release |
| sda_i | input | 1 | Data line level |

## Verification
The assertions check every cycle that the data line only changes while the clock is high at a START or STOP. They also check that each clock high pulse is exactly as long as its count, that the clock stays low while a write waits for data, and that a received byte never overwrites an unread one. Byte order, the address byte contents, the acknowledge pattern of a read and what an address or data NAK cuts short can only be shown by the bench scenarios. The bench plays the target device for these, as it does for the clearing of status by the next command.

// File: rtl/twm_pkg.sv
package twm_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_STA_A,
      ST_STA_B,
      ST_LOW,
      ST_HIGH,
      ST_NEXT,
      ST_STO_A,
      ST_STO_B,
      ST_STO_C
   } twm_state_t;

   localparam int STAT_W    = 5;
   localparam int SB_DONE   = 0;
   localparam int SB_TXRDY  = 1;
   localparam int SB_RXRDY  = 2;
   localparam int SB_ANAK   = 3;
   localparam int SB_DNAK   = 4;
   localparam int BYTE_W    = 8;
   localparam int ACK_SLOT  = 8;
endpackage

// File: rtl/twm_phase_tmr.sv
module twm_phase_tmr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/twm_hold.sv
module twm_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fill,
   input  logic [W-1:0] fill_data,
   input  logic         drain,
   output logic         full,
   output logic [W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else begin
         if (fill) begin
            full <= 1'b1;
            data <= fill_data;
         end else if (drain) begin
            full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/twm_master.sv
module twm_master
   import twm_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int DIV_W    = 8,
   parameter int SDA_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic             cmd_start,
   input  logic             cmd_read,
   input  logic [6:0]       cmd_addr,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic [DIV_W-1:0] div_high,
   input  logic [DIV_W-1:0] div_low,
   input  logic             tx_wr,
   input  logic [7:0]       tx_data,
   input  logic             rx_rd,
   output logic [7:0]       rx_data,
   input  logic [4:0]       int_en,
   output logic             idle,
   output logic             cmd_done,
   output logic             tx_ready,
   output logic             rx_ready,
   output logic             addr_nak,
   output logic             data_nak,
   output logic             irq,
   output logic             scl_o,
   output logic             sda_o,
   input  logic             sda_i
);
   localparam int BIT_W = $clog2(ACK_SLOT + 1);
   localparam logic [BIT_W-1:0] ACK_IDX = BIT_W'(ACK_SLOT);

   generate
      if (CNT_W < 1 || DIV_W < 2 || SDA_SYNC < 0 || SDA_SYNC > 4) begin : g_bad_param
         $error("twm_master: parameter out of range");
      end
   endgenerate

   twm_state_t st, st_n;
   logic [BYTE_W-1:0] shreg;
   logic [BIT_W-1:0]  bitn;
   logic              data_ph, dir_rd, sda_q;
   logic [CNT_W-1:0]  remain;
   logic              done_q, anak_q, dnak_q;
   logic              sda_s;

   // input synchroniser variant chosen by parameter
   generate
      if (SDA_SYNC == 0) begin : g_nosync
         assign sda_s = sda_i;
      end else begin : g_sync
         logic [SDA_SYNC-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else begin
               ff[0] <= sda_i;
               for (int i = 1; i < SDA_SYNC; i++) ff[i] <= ff[i-1];
            end
         end
         assign sda_s = ff[SDA_SYNC-1];
      end
   endgenerate

   // phase timer
   logic             tmr_ld, tmr_done;
   logic [DIV_W-1:0] tmr_val, dh_m1, dl_m1;
   assign dh_m1 = div_high - 1'b1;
   assign dl_m1 = div_low - 1'b1;

   twm_phase_tmr #(.W(DIV_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .done(tmr_done)
   );

   // holding registers
   logic tx_take, tx_full, rx_take, rx_full;
   logic [7:0] tx_hold;

   twm_hold #(.W(BYTE_W)) u_txbuf (
      .clk(clk), .rst_n(rst_n), .fill(tx_wr), .fill_data(tx_data),
      .drain(tx_take), .full(tx_full), .data(tx_hold)
   );

   twm_hold #(.W(BYTE_W)) u_rxbuf (
      .clk(clk), .rst_n(rst_n), .fill(rx_take), .fill_data(shreg),
      .drain(rx_rd), .full(rx_full), .data(rx_data)
   );

   // next-state decision
   logic accept, sample, start_byte, set_anak, set_dnak, set_done;

   always_comb begin
      st_n       = st;
      tmr_ld     = 1'b0;
      tmr_val    = dh_m1;
      accept     = 1'b0;
      sample     = 1'b0;
      start_byte = 1'b0;
      tx_take    = 1'b0;
      rx_take    = 1'b0;
      set_anak   = 1'b0;
      set_dnak   = 1'b0;
      set_done   = 1'b0;
      unique case (st)
         ST_IDLE: if (cmd_wr && cmd_start) begin
            accept = 1'b1; st_n = ST_STA_A; tmr_ld = 1'b1; tmr_val = dh_m1;
         end
         ST_STA_A: if (tmr_done) begin
            st_n = ST_STA_B; tmr_ld = 1'b1; tmr_val = dh_m1;
         end
         ST_STA_B: if (tmr_done) begin
            st_n = ST_LOW; tmr_ld = 1'b1; tmr_val = dl_m1;
         end
         ST_LOW: if (tmr_done) begin
            st_n = ST_HIGH; tmr_ld = 1'b1; tmr_val = dh_m1;
         end
         ST_HIGH: if (tmr_done) begin
            sample = 1'b1;
            tmr_ld = 1'b1;
            tmr_val = dl_m1;
            if (bitn != ACK_IDX) begin
               st_n = ST_LOW;
            end else if (!data_ph) begin
               if (sda_s) begin
                  set_anak = 1'b1; st_n = ST_STO_A;
               end else begin
                  st_n = (remain == '0) ? ST_STO_A : ST_NEXT;
               end
            end else if (!dir_rd) begin
               if (sda_s) begin
                  set_dnak = 1'b1; st_n = ST_STO_A;
               end else begin
                  st_n = (remain == '0) ? ST_STO_A : ST_NEXT;
               end
            end else begin
               rx_take = 1'b1;
               st_n = (remain == '0) ? ST_STO_A : ST_NEXT;
            end
         end
         ST_NEXT: if (dir_rd ? !rx_full : tx_full) begin
            start_byte = 1'b1;
            tx_take    = !dir_rd;
            st_n       = ST_LOW;
            tmr_ld     = 1'b1;
            tmr_val    = dl_m1;
         end
         ST_STO_A: if (tmr_done) begin
            st_n = ST_STO_B; tmr_ld = 1'b1; tmr_val = dh_m1;
         end
         ST_STO_B: if (tmr_done) begin
            st_n = ST_STO_C; tmr_ld = 1'b1; tmr_val = dh_m1;
         end
         ST_STO_C: if (tmr_done) begin
            st_n = ST_IDLE; set_done = 1'b1;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   // bit the master puts on the data line during a low phase
   logic drive_bit;
   always_comb begin
      if (bitn == ACK_IDX) drive_bit = (data_ph && dir_rd) ? (remain == '0) : 1'b1;
      else                 drive_bit = (data_ph && dir_rd) ? 1'b1 : shreg[BYTE_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         sda_q   <= 1'b1;
         shreg   <= '0;
         bitn    <= '0;
         data_ph <= 1'b0;
         dir_rd  <= 1'b0;
         remain  <= '0;
         done_q  <= 1'b0;
         anak_q  <= 1'b0;
         dnak_q  <= 1'b0;
      end else begin
         st <= st_n;
         case (st)
            ST_IDLE, ST_STA_A, ST_STO_C: sda_q <= 1'b1;
            ST_STA_B, ST_STO_A:          sda_q <= 1'b0;
            ST_LOW:                      sda_q <= drive_bit;
            default:                     sda_q <= sda_q;
         endcase
         if (accept) begin
            shreg   <= {cmd_addr, cmd_read};
            dir_rd  <= cmd_read;
            remain  <= cmd_count;
            bitn    <= '0;
            data_ph <= 1'b0;
            done_q  <= 1'b0;
            anak_q  <= 1'b0;
            dnak_q  <= 1'b0;
         end
         if (sample && bitn != ACK_IDX) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            bitn  <= bitn + 1'b1;
         end
         if (start_byte) begin
            bitn    <= '0;
            data_ph <= 1'b1;
            remain  <= remain - 1'b1;
            if (!dir_rd) shreg <= tx_hold;
         end
         if (set_anak) anak_q <= 1'b1;
         if (set_dnak) dnak_q <= 1'b1;
         if (set_done) done_q <= 1'b1;
      end
   end

   assign scl_o    = (st == ST_IDLE) || (st == ST_STA_A) || (st == ST_STA_B) ||
                     (st == ST_HIGH) || (st == ST_STO_B) || (st == ST_STO_C);
   assign sda_o    = sda_q;
   assign idle     = (st == ST_IDLE);
   assign cmd_done = done_q;
   assign tx_ready = !tx_full;
   assign rx_ready = rx_full;
   assign addr_nak = anak_q;
   assign data_nak = dnak_q;

   // interrupt combine
   logic [STAT_W-1:0] stat, masked;
   always_comb begin
      stat           = '0;
      stat[SB_DONE]  = done_q;
      stat[SB_TXRDY] = !tx_full;
      stat[SB_RXRDY] = rx_full;
      stat[SB_ANAK]  = anak_q;
      stat[SB_DNAK]  = dnak_q;
   end
   generate
      for (genvar g = 0; g < STAT_W; g++) begin : g_irq
         assign masked[g] = stat[g] & int_en[g];
      end
   endgenerate
   assign irq = |masked;

   // checker state: length of the current clock high pulse
   logic [DIV_W:0] hi_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_len <= '0;
      else if (scl_o) hi_len <= hi_len + 1'b1;
      else            hi_len <= '0;
   end

   // R2
   left_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st == ST_IDLE) && st != ST_IDLE) |-> $past(cmd_wr && cmd_start));
   // R10
   sda_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o && $past(scl_o) && $rose(sda_o)) |-> (st == ST_STO_C));
   // R10
   sda_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o && $past(scl_o) && $fell(sda_o)) |-> (st == ST_STA_B));
   // R4
   anak_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(anak_q) |-> (st == ST_STO_A));
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> idle);
   // R7
   rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_take |-> !rx_full);
   // R6
   stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_NEXT && !dir_rd && !tx_full) |=> !scl_o);
   // R11
   high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st == ST_HIGH) && st == ST_LOW && $stable(div_high)) |-> (hi_len == {1'b0, div_high}));
endmodule

// File: tb/twm_master_test.sv
module twm_master_test;
   localparam int CLK_P = 10;
   localparam int DIV_H = 4;
   localparam int DIV_L = 3;
   localparam logic [6:0] SLV_ADDR = 7'h2A;

   logic clk = 1'b0;
   logic rst_n;
   logic cmd_wr, cmd_start, cmd_read;
   logic [6:0] cmd_addr;
   logic [7:0] cmd_count;
   logic [7:0] div_high, div_low;
   logic tx_wr, rx_rd;
   logic [7:0] tx_data, rx_data;
   logic [4:0] int_en;
   logic idle, cmd_done, tx_ready, rx_ready, addr_nak, data_nak, irq;
   logic scl_o, sda_o, sda_line;
   logic slv_sda;

   assign sda_line = sda_o & slv_sda;

   always #(CLK_P/2) clk = ~clk;

   twm_master uut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_start(cmd_start), .cmd_read(cmd_read),
      .cmd_addr(cmd_addr), .cmd_count(cmd_count), .div_high(div_high), .div_low(div_low),
      .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data), .int_en(int_en),
      .idle(idle), .cmd_done(cmd_done), .tx_ready(tx_ready), .rx_ready(rx_ready),
      .addr_nak(addr_nak), .data_nak(data_nak), .irq(irq),
      .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_line)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural target device and bus monitor
   int  starts = 0, stops = 0, rises = 0;
   int  bc, dbyte, nak_idx = -1;
   bit  ps, pd, in_addr, sel, rd_mode, rd_act;
   logic [7:0] sh, cur;
   logic [7:0] abytes[$], wbytes[$], src[$];
   int  mack[$];
   longint cyc = 0, hi_t = 0;
   int  hi_bad = 0, hi_n = 0;
   bit  hi_open = 0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         ps = 1; pd = 1; slv_sda = 1; bc = 0; sel = 0; in_addr = 0; rd_act = 0;
         hi_open = 0;
      end else begin
         if (scl_o && ps && pd && !sda_line) begin
            starts++; bc = 0; in_addr = 1; sh = 0; slv_sda = 1; dbyte = 0; sel = 0;
            rd_act = 0; hi_open = 0;
         end else if (scl_o && ps && !pd && sda_line) begin
            stops++; hi_open = 0; sel = 0; rd_act = 0;
         end else if (scl_o && !ps) begin
            rises++; hi_open = 1; hi_t = cyc;
            if (bc < 8) begin
               sh = {sh[6:0], sda_line};
               bc++;
            end else begin
               if (in_addr) rd_act = sel && rd_mode && !sda_line;
               else if (sel && rd_mode) begin
                  mack.push_back(int'(sda_line));
                  rd_act = !sda_line;
               end
               if (rd_act) cur = (src.size() > 0) ? src.pop_front() : 8'hFF;
               in_addr = 0;
               bc = 0;
            end
         end else if (!scl_o && ps) begin
            if (hi_open) begin
               hi_n++;
               if (cyc - hi_t != DIV_H) hi_bad++;
               hi_open = 0;
            end
            if (bc == 8) begin
               if (in_addr) begin
                  abytes.push_back(sh);
                  rd_mode = sh[0];
                  sel = (sh[7:1] == SLV_ADDR);
                  slv_sda = !sel;
               end else if (sel && !rd_mode) begin
                  wbytes.push_back(sh);
                  slv_sda = (dbyte == nak_idx);
                  dbyte++;
               end else slv_sda = 1;
            end else if (!in_addr && rd_act) begin
               slv_sda = cur[7 - bc];
            end else slv_sda = 1;
         end
         ps = scl_o; pd = sda_line;
      end
   end

   task automatic issue(input logic [6:0] a, input logic rd, input logic [7:0] n, input logic go);
      @(negedge clk);
      cmd_wr = 1; cmd_addr = a; cmd_read = rd; cmd_count = n; cmd_start = go;
      @(negedge clk);
      cmd_wr = 0; cmd_start = 0;
   endtask

   task automatic tx_write(input logic [7:0] d);
      @(negedge clk);
      tx_wr = 1; tx_data = d;
      @(negedge clk);
      tx_wr = 0;
   endtask

   task automatic wait_idle();
      while (!idle) @(negedge clk);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      int r0;
      rst_n = 0; cmd_wr = 0; cmd_start = 0; cmd_read = 0; cmd_addr = 0; cmd_count = 0;
      div_high = 8'(DIV_H); div_low = 8'(DIV_L); tx_wr = 0; tx_data = 0; rx_rd = 0; int_en = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 idle", idle, 1);
      chk("R1 scl", scl_o, 1);
      chk("R1 sda", sda_o, 1);
      chk("R1 tx_ready", tx_ready, 1);
      chk("R1 rx_ready", rx_ready, 0);
      chk("R1 flags", {cmd_done, addr_nak, data_nak}, 0);
      chk("R12 irq masked", irq, 0);

      // R2 command without start request
      issue(SLV_ADDR, 0, 8'd2, 0);
      repeat (40) @(negedge clk);
      chk("R2 stays idle", idle, 1);
      chk("R2 no start", starts, 0);
      chk("R2 scl released", scl_o, 1);

      // write of three bytes with a stalled second byte (R3 R5 R6)
      tx_write(8'hA5);
      issue(SLV_ADDR, 0, 8'd3, 1);
      while (!tx_ready) @(negedge clk);
      r0 = rises;
      repeat (100) @(negedge clk);
      chk("R6 write stall rises", rises - r0, 9);
      chk("R6 write stall scl low", scl_o, 0);
      tx_write(8'h3C);
      while (!tx_ready) @(negedge clk);
      tx_write(8'hFF);
      wait_idle();
      chk("R3 address byte", abytes[abytes.size()-1], 8'h54);
      chk("R5 byte count", wbytes.size(), 3);
      chk("R5 byte0", wbytes[0], 8'hA5);
      chk("R5 byte1", wbytes[1], 8'h3C);
      chk("R5 byte2", wbytes[2], 8'hFF);
      chk("R9 done", cmd_done, 1);
      chk("R9 stop", stops, 1);
      chk("R9 naks clear", {addr_nak, data_nak}, 0);

      // R12 interrupt masking
      @(negedge clk); int_en = 5'b00001;
      @(negedge clk); chk("R12 done enabled", irq, 1);
      int_en = 5'b00100;
      @(negedge clk); chk("R12 rx enabled empty", irq, 0);
      int_en = 5'b00010;
      @(negedge clk); chk("R12 tx enabled", irq, 1);
      int_en = 0;

      // read of three bytes with a stalled reader (R3 R6 R7)
      src = '{8'h5A, 8'hC3, 8'h81};
      issue(SLV_ADDR, 1, 8'd3, 1);
      for (int i = 0; i < 3; i++) begin
         while (!rx_ready) @(negedge clk);
         if (i == 0) begin
            r0 = rises;
            repeat (80) @(negedge clk);
            chk("R6 read stall rises", rises - r0, 0);
            chk("R6 read stall scl low", scl_o, 0);
         end
         chk("R7 rx byte", rx_data, (i == 0) ? 8'h5A : (i == 1) ? 8'hC3 : 8'h81);
         @(negedge clk); rx_rd = 1;
         @(negedge clk); rx_rd = 0;
      end
      wait_idle();
      chk("R3 read address byte", abytes[abytes.size()-1], 8'h55);
      chk("R7 ack count", mack.size(), 3);
      chk("R7 ack first", mack[0], 0);
      chk("R7 ack second", mack[1], 0);
      chk("R7 nak last", mack[2], 1);
      chk("R7 rx drained", rx_ready, 0);
      chk("R9 read done", cmd_done, 1);

      // R4 address not acknowledged
      issue(7'h11, 1, 8'd2, 1);
      wait_idle();
      chk("R4 anak", addr_nak, 1);
      chk("R4 done", cmd_done, 1);
      chk("R4 address byte", abytes[abytes.size()-1], 8'h23);
      chk("R4 no data", mack.size(), 3);
      chk("R4 no rx", rx_ready, 0);
      chk("R4 stop", stops, 3);

      // R13 zero count, also clears addr_nak (R9)
      issue(SLV_ADDR, 0, 8'd0, 1);
      wait_idle();
      chk("R9 anak cleared", addr_nak, 0);
      chk("R13 done", cmd_done, 1);
      chk("R13 no data", wbytes.size(), 3);
      chk("R13 address", abytes[abytes.size()-1], 8'h54);
      chk("R13 stop", stops, 4);

      // R8 data nak on second byte
      nak_idx = 1;
      tx_write(8'h11);
      issue(SLV_ADDR, 0, 8'd3, 1);
      while (!tx_ready) @(negedge clk);
      tx_write(8'h22);
      wait_idle();
      chk("R8 dnak", data_nak, 1);
      chk("R8 bytes sent", wbytes.size(), 5);
      chk("R8 last byte", wbytes[4], 8'h22);
      chk("R8 stop", stops, 5);
      chk("R8 buffer untouched", tx_ready, 1);

      // R10 R11 bus shape over the whole run
      chk("R10 starts", starts, 5);
      chk("R10 stops", stops, 5);
      chk("R11 high pulses seen", int'(hi_n > 0), 1);
      chk("R11 high width", hi_bad, 0);

      finished = 1;
      summary();
      $finish;
   end
endmodule